// File: doc/BRIEF.md
# Pipelined Ones Counter for Comparator Arrays

This block turns a wide vector of comparator decisions into a binary count of how many of those decisions are high. In a converter whose comparators carry large random offsets, the decision vector is often not a clean thermometer code. Bits appear out of order, and low bits can sit above high ones. The block therefore treats every input bit the same way, whatever its position. It simply adds them up, so any bubbled or scrambled pattern reduces to the correct total with no correction step.

The sum is formed by a carry-save reduction tree built from full-adder cells. Each adder level merges groups of three bits of one weight into a sum bit of that weight and a carry bit of the next weight. For the default 63-bit input, the tree needs nine adder levels. A register stage sits after every two levels, which gives five stages. The block accepts one vector per clock, without stalls. A valid flag travels alongside the data, and the data registers of a stage load only when that stage receives a valid word. Input masking, comparator circuits and bubble-correction heuristics are handled elsewhere.

Top module: `ones_count_pipe`

## Requirements
- R1: `count` is the number of bits set in the `inVec` that was accepted, as an unsigned 6-bit binary value in the range 0 to 63.
- R2: The result does not depend on bit positions. A single set bit at any of the 63 positions gives 1, and non-thermometer (bubbled) patterns are counted exactly as they are, with no correction.
- R3: A vector accepted on a rising edge with `inValid` high appears on `count`, with `outValid` high, after the fifth rising edge, counting the accepting edge as the first. `outValid` is low in every cycle for which no vector was accepted five edges earlier.
- R4: A new vector can be accepted on every edge. Back-to-back inputs give results on consecutive cycles, in the order of input.
- R5: A rising edge with `rst` high clears `outValid` and `count` to 0 and discards every vector still inside the pipeline.
- R6: While `outValid` is low, `count` keeps the last value it delivered (0 after reset).
- R7: An all-zero vector gives 0 and an all-one vector gives 63.
- R8: A vector presented with `inValid` low is ignored. It produces no result and leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | `inVec` holds a vector to be counted |
| inVec | input | 63 | Comparator decision vector; all bits have equal weight |
| outValid | output | 1 | `count` holds a new result in this cycle |
| count | output | 6 | Number of ones in the matching accepted vector |

## Verification
Each accepted vector is due on the outputs exactly five rising edges after the edge that accepts it. The bench records that due cycle, together with a reference ones count computed by a bit loop, in a scoreboard queue at the moment it drives the vector. A monitor samples two nanoseconds after every rising edge. When `outValid` is high, it checks both the value and the cycle number of the popped entry. When `outValid` is low, it checks that no entry has come due and that `count` has held its value. A reset raised while vectors are in flight empties the queue, and the monitor then requires cleared outputs on the edges where reset was high.

// File: rtl/ones_tree_pkg.sv
package ones_tree_pkg;

  // Upper bounds for the elaboration-time column bookkeeping.
  localparam int MaxCols   = 32;
  localparam int MaxLevels = 64;

  // Number of full adders placed on a column of c bits. When no column of a
  // level holds three or more bits, a column of two bits gets one adder with
  // a zero third input so the reduction still advances.
  function automatic int faOf(int c, bit pad);
    return c / 3 + ((pad && (c % 3 == 2)) ? 1 : 0);
  endfunction

  // Bits of a column that pass through a level untouched.
  function automatic int leftOf(int c, bit pad);
    return (pad && (c % 3 == 2)) ? 0 : c % 3;
  endfunction

  // Bit count of column col entering adder level lvl.
  function automatic int colCount(int inW, int outW, int lvl, int col);
    int cur [MaxCols];
    int nxt [MaxCols];
    bit pad;
    for (int w = 0; w < MaxCols; w++) begin
      cur[w] = 0;
      nxt[w] = 0;
    end
    cur[0] = inW;
    for (int i = 0; i < lvl; i++) begin
      pad = 1'b1;
      for (int w = 0; w < outW; w++) if (cur[w] >= 3) pad = 1'b0;
      for (int w = 0; w < outW; w++) begin
        nxt[w] = faOf(cur[w], pad) + leftOf(cur[w], pad);
        if (w > 0) nxt[w] = nxt[w] + faOf(cur[w-1], pad);
      end
      for (int w = 0; w < outW; w++) cur[w] = nxt[w];
    end
    if (col < 0 || col >= outW) return 0;
    return cur[col];
  endfunction

  // True when adder level lvl works in the padded (two-bit) regime.
  function automatic bit levelPad(int inW, int outW, int lvl);
    for (int w = 0; w < outW; w++)
      if (colCount(inW, outW, lvl, w) >= 3) return 1'b0;
    return 1'b1;
  endfunction

  // Flat offset of column col in the bit vector entering level lvl.
  function automatic int colBase(int inW, int outW, int lvl, int col);
    int acc = 0;
    for (int v = 0; v < col; v++) acc += colCount(inW, outW, lvl, v);
    return acc;
  endfunction

  function automatic int totBits(int inW, int outW, int lvl);
    return colBase(inW, outW, lvl, outW);
  endfunction

  // Adder levels until every column holds at most one bit.
  function automatic int levelCount(int inW, int outW);
    bit done;
    for (int l = 0; l < MaxLevels; l++) begin
      done = 1'b1;
      for (int w = 0; w < outW; w++)
        if (colCount(inW, outW, l, w) > 1) done = 1'b0;
      if (done) return (l < 1) ? 1 : l;
    end
    return MaxLevels;
  endfunction

endpackage

// File: rtl/ones_tree_fa.sv
module ones_tree_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/ones_tree_ctrl.sv
module ones_tree_ctrl #(
  parameter int NSTG = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output logic [NSTG-1:0] stageAdv,
  output logic            clear,
  output logic            outValid
);
  logic [NSTG-1:0] vld;

  // Stage s loads when the word feeding it is valid.
  always_comb begin
    stageAdv[0] = inValid;
    for (int s = 1; s < NSTG; s++) stageAdv[s] = vld[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= stageAdv;
  end

  assign clear    = rst;
  assign outValid = vld[NSTG-1];

  // R5: after a reset edge no stage claims a valid word.
  a_r5_flush_valid: assert property (@(posedge clk) rst |=> (vld == '0));

endmodule

// File: rtl/ones_tree_path.sv
module ones_tree_path
  import ones_tree_pkg::*;
#(
  parameter int IN_W         = 63,
  parameter int OUT_W        = 6,
  parameter int LVLS_PER_STG = 2,
  parameter int NLVL         = 9,
  parameter int NSTG         = 5
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [NSTG-1:0]  stageAdv,
  input  logic [IN_W-1:0]  vecIn,
  output logic [OUT_W-1:0] count
);

  for (genvar l = 0; l < NLVL; l++) begin : lv
    localparam int  TI      = totBits(IN_W, OUT_W, l);
    localparam int  TO      = totBits(IN_W, OUT_W, l + 1);
    localparam bit  PAD     = levelPad(IN_W, OUT_W, l);
    localparam bit  HAS_REG = (((l + 1) % LVLS_PER_STG) == 0) || (l == NLVL - 1);
    localparam int  STG     = l / LVLS_PER_STG;

    logic [TI-1:0] src;
    logic [TO-1:0] res;
    logic [TO-1:0] outq;

    if (l == 0) begin : g_src_in
      assign src = vecIn;
    end else begin : g_src_prev
      assign src = lv[l-1].outq;
    end

    for (genvar w = 0; w < OUT_W; w++) begin : col
      localparam int C   = colCount(IN_W, OUT_W, l, w);
      localparam int B   = colBase(IN_W, OUT_W, l, w);
      localparam int F   = faOf(C, PAD);
      localparam int L   = leftOf(C, PAD);
      localparam int NB  = colBase(IN_W, OUT_W, l + 1, w);
      localparam int CU  = colCount(IN_W, OUT_W, l, w + 1);
      localparam int UPB = (w < OUT_W - 1)
                         ? colBase(IN_W, OUT_W, l + 1, w + 1) + faOf(CU, PAD) + leftOf(CU, PAD)
                         : 0;

      for (genvar k = 0; k < F; k++) begin : fa
        logic thirdBit;
        if (3 * k + 2 < C) begin : g_full
          assign thirdBit = src[B + 3*k + 2];
        end else begin : g_pad
          assign thirdBit = 1'b0;
        end
        if (w < OUT_W - 1) begin : g_cell
          ones_tree_fa u_fa (
            .a (src[B + 3*k]),
            .b (src[B + 3*k + 1]),
            .ci(thirdBit),
            .s (res[NB + k]),
            .co(res[UPB + k])
          );
        end else begin : g_top
          // A carry out of the top column would weigh 2**OUT_W; it is always zero.
          assign res[NB + k] = src[B + 3*k] ^ src[B + 3*k + 1] ^ thirdBit;
        end
      end

      for (genvar j = 0; j < L; j++) begin : pass
        assign res[NB + F + j] = src[B + 3*F + j];
      end
    end

    if (HAS_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (clear)              outq <= '0;
        else if (stageAdv[STG]) outq <= res;
      end
    end else begin : g_wire
      assign outq = res;
    end
  end

  for (genvar w = 0; w < OUT_W; w++) begin : outMap
    if (colCount(IN_W, OUT_W, NLVL, w) == 1) begin : g_bit
      assign count[w] = lv[NLVL-1].outq[colBase(IN_W, OUT_W, NLVL, w)];
    end else begin : g_zero
      assign count[w] = 1'b0;
    end
  end

endmodule

// File: rtl/ones_count_pipe.sv
module ones_count_pipe
  import ones_tree_pkg::*;
#(
  parameter  int IN_W         = 63,
  parameter  int LVLS_PER_STG = 2,
  localparam int OUT_W        = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inVec,
  output logic             outValid,
  output logic [OUT_W-1:0] count
);
  localparam int NLVL = levelCount(IN_W, OUT_W);
  localparam int NSTG = (NLVL + LVLS_PER_STG - 1) / LVLS_PER_STG;
  localparam int SW   = $clog2(NSTG + 1);

  logic [NSTG-1:0] stageAdv;
  logic            clear;

  ones_tree_ctrl #(.NSTG(NSTG)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .stageAdv(stageAdv),
    .clear   (clear),
    .outValid(outValid)
  );

  ones_tree_path #(
    .IN_W        (IN_W),
    .OUT_W       (OUT_W),
    .LVLS_PER_STG(LVLS_PER_STG),
    .NLVL        (NLVL),
    .NSTG        (NSTG)
  ) u_path (
    .clk     (clk),
    .clear   (clear),
    .stageAdv(stageAdv),
    .vecIn   (inVec),
    .count   (count)
  );

  // Edges since reset, saturating at the pipeline depth; used only to keep
  // the latency checks from looking back past the reset.
  logic [SW-1:0] settleCnt;
  always_ff @(posedge clk) begin
    if (rst)                          settleCnt <= '0;
    else if (settleCnt != SW'(NSTG))  settleCnt <= settleCnt + 1'b1;
  end

  a_r1_matches_ones: assert property (@(posedge clk) disable iff (rst)
    (outValid && settleCnt == SW'(NSTG)) |-> (32'(count) == $past($countones(inVec), NSTG)));

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (settleCnt == SW'(NSTG)) |-> (outValid == $past(inValid, NSTG)));

  a_r5_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && count == '0));

  a_r6_hold_count: assert property (@(posedge clk) disable iff (rst)
    (!outValid && !$past(rst)) |-> $stable(count));

endmodule

// File: tb/tb_ones_count_pipe.sv
module tb_ones_count_pipe;
  localparam int IN_W = 63;
  localparam int LAT  = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inValid = 1'b0;
  logic [IN_W-1:0] inVec = '0;
  logic            outValid;
  logic [5:0]      count;

  int total = 0;
  int bad   = 0;
  int cycCnt = 0;
  int lastCount = 0;
  int expQ[$];
  int dueQ[$];
  string tagQ[$];

  ones_count_pipe dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(inVec),
    .outValid(outValid), .count(count)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d act=%0d exp=%0d", tag, cycCnt, act, exp);
    end
  endtask

  function automatic int refOnes(input logic [IN_W-1:0] v);
    int n = 0;
    for (int i = 0; i < IN_W; i++) if (v[i]) n++;
    return n;
  endfunction

  // Monitor: samples 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (rst) begin
      chk(!outValid, "R5 outValid under reset", int'(outValid), 0);
      chk(count == 6'd0, "R5 count under reset", int'(count), 0);
      lastCount = 0;
    end else if (outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R3 unexpected outValid", 1, 0);
      end else begin
        int e;
        int d;
        string t;
        e = expQ.pop_front();
        d = dueQ.pop_front();
        t = tagQ.pop_front();
        chk(cycCnt == d, {"R3 R4 timing ", t}, cycCnt, d);
        chk(int'(count) == e, {"R1 ", t}, int'(count), e);
        lastCount = int'(count);
      end
    end else begin
      if (dueQ.size() > 0 && dueQ[0] <= cycCnt)
        chk(1'b0, "R3 missing result", cycCnt, dueQ[0]);
      chk(int'(count) == lastCount, "R6 R8 count held", int'(count), lastCount);
    end
  end

  task automatic send(input logic [IN_W-1:0] v, input bit valid, input string tag);
    @(negedge clk);
    inVec   = v;
    inValid = valid;
    if (valid) begin
      expQ.push_back(refOnes(v));
      dueQ.push_back(cycCnt + LAT);
      tagQ.push_back(tag);
    end
  endtask

  function automatic logic [IN_W-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[IN_W-1:0];
  endfunction

  always @(posedge clk) begin
    if (cycCnt > 50000) begin
      total++;
      bad++;
      $display("FAIL watchdog cycle=%0d act=%0d exp=%0d", cycCnt, cycCnt, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    send('0, 1'b1, "R7 all zero");
    send('1, 1'b1, "R7 all one");
    send('0, 1'b0, "idle");

    for (int i = 0; i < IN_W; i++) begin
      logic [IN_W-1:0] v;
      v = '0;
      v[i] = 1'b1;
      send(v, 1'b1, "R2 single bit");
    end

    // Thermometer codes with a bubble: one ones bit moved above the edge.
    for (int n = 2; n < IN_W; n++) begin
      logic [IN_W-1:0] v;
      v = '0;
      for (int i = 0; i < n; i++) v[i] = 1'b1;
      v[n-2] = 1'b0;
      v[n]   = 1'b1;
      send(v, 1'b1, "R2 bubbled code");
    end

    for (int i = 0; i < 300; i++) send(rnd(), 1'b1, "R4 back-to-back random");

    for (int i = 0; i < 300; i++) begin
      bit v;
      v = ($urandom() % 3) == 0;
      send(rnd(), v, v ? "R1 random gapped" : "R8 ignored");
    end

    repeat (LAT + 2) send(rnd(), 1'b0, "R8 ignored");

    // Reset while vectors are in flight.
    send('1, 1'b1, "R5 pre-reset");
    send(rnd(), 1'b1, "R5 pre-reset");
    send(rnd(), 1'b1, "R5 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    expQ.delete();
    dueQ.delete();
    tagQ.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;

    send('1, 1'b1, "R7 after reset");
    for (int i = 0; i < 20; i++) send(rnd(), 1'b1, "R4 after reset");
    repeat (LAT + 3) send(rnd(), 1'b0, "R8 drain");

    @(negedge clk);
    chk(expQ.size() == 0, "R3 all results delivered", expQ.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule